// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Unit

This block sits beside the control sequencer of a 16-bit processor and handles its single external interrupt request line. It holds the global interrupt-enable flag, which the core's enable, disable and return-from-interrupt commands change. When that flag is set, the request line is high and the core reports that it is between instructions, the block accepts the interrupt. It then drops the enable flag and starts an acknowledge bus cycle.

During the acknowledge cycle the interrupting device drives its interrupt number onto the low byte of the data bus and raises a data-valid strobe. The block captures the byte and forms the handler's vector address. The vector table is a 256-word page placed directly below the memory-mapped I/O page. The block presents that address with a valid strobe until the core takes it. Separately, the block decodes every bus address and flags any access that falls in the I/O page.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset `int_en`, `ack_o` and `vec_valid` are all low.
- R2: A `cmd_eni` or `cmd_rti` pulse sets `int_en` from the next clock edge, and a `cmd_dsi` pulse clears it. When `cmd_dsi` coincides with `cmd_eni` or `cmd_rti`, the clear wins.
- R3: In the idle state, with `int_en`, `irq_req` and `insn_boundary` all high at a clock edge, `ack_o` is high from that edge on.
- R4: A request that arrives while `insn_boundary` is low, or while `int_en` is low, starts no acknowledge. It is taken at the first later edge where all three conditions hold.
- R5: Accepting an interrupt clears `int_en` at the same edge, even if `cmd_eni` or `cmd_rti` is high in that cycle.
- R6: `ack_o` stays high until an edge with `ack_data_valid` high. At that edge `data_bus[7:0]` is captured, `ack_o` falls and `vec_valid` rises.
- R7: While `vec_valid` is high, `vec_addr` equals 0xFE00 plus the captured byte, and bits 15:8 of `data_bus` have no effect on it.
- R8: `vec_valid` and `vec_addr` hold until an edge with `vec_ready` high. After that edge `vec_valid` is low and the unit is idle again.
- R9: `io_access` is high, with no clock delay, exactly when `bus_addr` lies in 0xFF00..0xFFFF.
- R10: `ack_o` and `vec_valid` are never high together, and no new interrupt is accepted before the unit returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| insn_boundary | input | 1 | Core is between instructions |
| cmd_eni | input | 1 | Enable-interrupts command pulse |
| cmd_dsi | input | 1 | Disable-interrupts command pulse |
| cmd_rti | input | 1 | Return-from-interrupt command pulse |
| ack_data_valid | input | 1 | Device has put its interrupt number on the data bus |
| data_bus | input | 16 | Data bus. Only the low byte is used |
| vec_ready | input | 1 | Core takes the vector address |
| bus_addr | input | 16 | Current bus address for the I/O page decode |
| ack_o | output | 1 | Interrupt acknowledge cycle in progress |
| vec_valid | output | 1 | Vector address is valid |
| vec_addr | output | 16 | Vector-table address of the handler pointer |
| io_access | output | 1 | Bus address is in the I/O page |
| int_en | output | 1 | Global interrupt-enable flag |

## Verification
Acceptance of a request and an enable command (`cmd_eni` or `cmd_rti`) can land on the same edge. Both write the enable flag, and R5 requires the clear from acceptance to win. A directed step raises `cmd_eni` on the exact edge where the request is first taken. The random phase drives every command line independently while requests and boundaries toggle, so such collisions recur many times. Each case is judged by comparing `int_en` and `ack_o` in the following cycle against a bench model that applies the priority order: accept, then disable, then enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACK    = 2'd1,
    ST_VECTOR = 2'd2
  } irq_state_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_eni,
  input  logic set_rti,
  input  logic clr_dsi,
  input  logic clr_accept,
  output logic int_en
);
  logic en_q, en_d, en_we;

  // priority: acceptance clear, then disable, then enable/return
  always_comb begin
    en_we = clr_accept | clr_dsi | set_eni | set_rti;
    if (clr_accept || clr_dsi) en_d = 1'b0;
    else                       en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign int_en = en_q;

  assert_dsi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dsi |=> !int_en);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eni || set_rti) && !clr_dsi && !clr_accept |=> int_en);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
#(
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_en,
  input  logic             irq_req,
  input  logic             insn_boundary,
  input  logic             ack_data_valid,
  input  logic [NUM_W-1:0] data_lo,
  input  logic             vec_ready,
  output logic             accept,
  output logic             ack_o,
  output logic             vec_valid,
  output logic [NUM_W-1:0] irq_num
);
  irq_state_e state_q, state_d;
  logic [NUM_W-1:0] num_q;
  logic num_we;

  always_comb begin
    accept  = (state_q == ST_IDLE) && int_en && irq_req && insn_boundary;
    num_we  = (state_q == ST_ACK) && ack_data_valid;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)         state_d = ST_ACK;
      ST_ACK:    if (ack_data_valid) state_d = ST_VECTOR;
      ST_VECTOR: if (vec_ready)      state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      num_q <= '0;
    else if (num_we) num_q <= data_lo;
  end

  assign ack_o     = (state_q == ST_ACK);
  assign vec_valid = (state_q == ST_VECTOR);
  assign irq_num   = num_q;

  assert_ack_vec_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && vec_valid));
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !ack_data_valid |=> ack_o);
  assert_ack_to_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && ack_data_valid |=> vec_valid && irq_num == $past(data_lo));
  assert_no_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o && !vec_valid && !insn_boundary |=> !ack_o);
  assert_vec_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid && !ack_o);
endmodule

// File: rtl/irq_addr_map.sv
module irq_addr_map #(
  parameter int              ADDR_W   = 16,
  parameter int              NUM_W    = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'hFF00
) (
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              io_access
);
  localparam int PAGE_W = ADDR_W - NUM_W;

  // table base is page aligned, so the number fills the low bits
  assign vec_addr  = {VEC_BASE[ADDR_W-1:NUM_W], irq_num};
  assign io_access = (bus_addr[ADDR_W-1:NUM_W] >= IO_BASE[ADDR_W-1:NUM_W]);

  always_comb begin
    assert_io_decode_R9: assert (io_access == (bus_addr >= IO_BASE));
  end

  if (PAGE_W < 1) begin : g_bad_width
    initial $error("address must be wider than the vector number");
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              insn_boundary,
  input  logic              cmd_eni,
  input  logic              cmd_dsi,
  input  logic              cmd_rti,
  input  logic              ack_data_valid,
  input  logic [DATA_W-1:0] data_bus,
  input  logic              vec_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ack_o,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              io_access,
  output logic              int_en
);
  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(16'hFE00);
  localparam logic [ADDR_W-1:0] IO_BASE  = ADDR_W'(16'hFF00);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       accept;
  logic [NUM_W-1:0] irq_num;
  logic       unused_data_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign unused_data_hi = ^data_bus[DATA_W-1:NUM_W];

  irq_enable_reg u_en (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_eni    (cmd_eni),
    .set_rti    (cmd_rti),
    .clr_dsi    (cmd_dsi),
    .clr_accept (accept),
    .int_en     (int_en)
  );

  irq_ack_fsm #(.NUM_W(NUM_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .int_en         (int_en),
    .irq_req        (irq_req),
    .insn_boundary  (insn_boundary),
    .ack_data_valid (ack_data_valid),
    .data_lo        (data_bus[NUM_W-1:0]),
    .vec_ready      (vec_ready),
    .accept         (accept),
    .ack_o          (ack_o),
    .vec_valid      (vec_valid),
    .irq_num        (irq_num)
  );

  irq_addr_map #(
    .ADDR_W  (ADDR_W),
    .NUM_W   (NUM_W),
    .VEC_BASE(VEC_BASE),
    .IO_BASE (IO_BASE)
  ) u_map (
    .irq_num   (irq_num),
    .bus_addr  (bus_addr),
    .vec_addr  (vec_addr),
    .io_access (io_access)
  );

  assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ack_o) |-> !int_en);
  assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |-> vec_addr[ADDR_W-1:NUM_W] == VEC_BASE[ADDR_W-1:NUM_W]);
  assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !ack_o && !vec_valid && !int_en);
endmodule

// File: tb/irq_vector_unit_tb.sv
`timescale 1ns/1ps
module irq_vector_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_req, insn_boundary, cmd_eni, cmd_dsi, cmd_rti, ack_data_valid, vec_ready;
  logic [15:0] data_bus, bus_addr, vec_addr;
  logic ack_o, vec_valid, io_access, int_en;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit       m_en;
  int       m_st;
  bit [7:0] m_num;

  always #4 clk = ~clk;

  irq_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .cmd_eni(cmd_eni), .cmd_dsi(cmd_dsi), .cmd_rti(cmd_rti),
    .ack_data_valid(ack_data_valid), .data_bus(data_bus), .vec_ready(vec_ready),
    .bus_addr(bus_addr), .ack_o(ack_o), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .io_access(io_access), .int_en(int_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_io(input logic [15:0] a);
    return a >= 16'hFF00;
  endfunction

  function automatic logic [15:0] exp_vec(input bit [7:0] n);
    return 16'hFE00 + {8'h00, n};
  endfunction

  task automatic compare_outputs();
    chk("R2 int_en", {31'd0, int_en}, {31'd0, m_en});
    chk("R3 ack_o", {31'd0, ack_o}, {31'd0, m_st == 1});
    chk("R8 vec_valid", {31'd0, vec_valid}, {31'd0, m_st == 2});
    if (m_st == 2) chk("R7 vec_addr", {16'd0, vec_addr}, {16'd0, exp_vec(m_num)});
    chk("R9 io_access", {31'd0, io_access}, {31'd0, exp_io(bus_addr)});
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(input bit req, input bit bnd, input bit eni, input bit dsi,
                      input bit rti, input bit dv, input bit rdy,
                      input logic [15:0] dat, input logic [15:0] adr);
    bit acc;
    @(negedge clk);
    irq_req = req; insn_boundary = bnd; cmd_eni = eni; cmd_dsi = dsi; cmd_rti = rti;
    ack_data_valid = dv; vec_ready = rdy; data_bus = dat; bus_addr = adr;
    #1;
    compare_outputs();
    @(posedge clk);
    acc = (m_st == 0) && m_en && req && bnd;
    if (acc)             m_en = 1'b0;
    else if (dsi)        m_en = 1'b0;
    else if (eni || rti) m_en = 1'b1;
    case (m_st)
      0: if (acc) m_st = 1;
      1: if (dv) begin m_st = 2; m_num = dat[7:0]; end
      2: if (rdy) m_st = 0;
      default: m_st = 0;
    endcase
  endtask

  task automatic idle_step();
    step(0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    irq_req = 0; insn_boundary = 0; cmd_eni = 0; cmd_dsi = 0; cmd_rti = 0;
    ack_data_valid = 0; vec_ready = 0; data_bus = '0; bus_addr = '0;
    m_en = 0; m_st = 0; m_num = 0;
    #20;
    chk("R1 int_en", {31'd0, int_en}, 32'd0);
    chk("R1 ack_o", {31'd0, ack_o}, 32'd0);
    chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle_step();

    // R4: request while disabled is ignored
    step(1, 1, 0, 0, 0, 0, 0, 16'h0, 16'hFEFF);
    step(0, 0, 1, 0, 0, 0, 0, 16'h0, 16'hFF00);   // R2 ENI
    step(0, 0, 1, 1, 0, 0, 0, 16'h0, 16'hFFFF);   // R2 DSI beats ENI
    step(0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0000);   // R2 RTI sets
    // R4: request mid-instruction waits
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, 16'h1234);
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, 16'h1234);
    // R3/R5: accept with ENI in the same cycle, enable still clears
    step(1, 1, 1, 0, 0, 0, 0, 16'h0, 16'hFF01);
    // R6: acknowledge held until data valid
    step(1, 1, 0, 0, 0, 0, 0, 16'hAB37, 16'h0);
    step(1, 1, 1, 0, 0, 0, 0, 16'hAB37, 16'h0);
    step(1, 1, 0, 0, 0, 1, 0, 16'hAB37, 16'h0);   // R7 high byte ignored: FE37
    // R8/R10: vector held, no new accept while busy
    step(1, 1, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    step(1, 1, 0, 0, 0, 0, 1, 16'hFFFF, 16'h0);
    step(0, 0, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    // number 0xFF gives 0xFEFF
    step(0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    step(1, 1, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    step(0, 0, 0, 0, 0, 1, 0, 16'h00FF, 16'h0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0, 16'h0);
    idle_step();

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 6) == 0,
           ($urandom % 9) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, 16'($urandom), 16'($urandom));
    end
    idle_step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule